// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a supervision timer with a small register port. A free-running clock passes through two scaling stages before it reaches the counter. The first stage is an 8-bit programmable prescaler that divides by P+1. The second stage divides by 16, 32, 64 or 128. The resulting tick decrements a 16-bit down-counter.

When the counter steps down to zero, the block can do either or both of two things, each under its own enable:
- raise a level interrupt, which stays set until software writes the control register;
- emit a single-cycle reset request.

On the next tick after reaching zero, the counter reloads from the reload register and counts again. Software keeps the system alive by rewriting the live count before it runs out.

The register port is a plain strobe, not a stream: `bus_valid_i` with `bus_write_i` high writes on the clock edge. With `bus_write_i` low, the addressed word appears combinationally on `bus_rdata_o`. There is no back-pressure. Every access completes in the cycle it is presented.

The control word layout is as follows:
- bit 0: reset-request enable;
- bit 2: interrupt enable;
- bits 4:3: divider select;
- bit 5: run;
- bits 15:8: prescaler value P.

The remaining bits are stored and read back unchanged.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control word at offset 0x00 reads 0x8021, the reload word at 0x04 reads 0x8000, the count at 0x08 reads 0x8000, and both `irq_o` and `rst_req_o` are low.
- R2: The control and reload words read back the last value written to them. A read of any address other than 0x00, 0x04 or 0x08 returns 0.
- R3: While running, the count decrements once every (P+1)·D clock cycles. P is control bits 15:8. D is selected by control bits 4:3: 00 gives 16, 01 gives 32, 10 gives 64, 11 gives 128.
- R4: The scaler state is cleared while bit 5 is low. The first decrement therefore comes exactly one full tick period after the edge that sets bit 5.
- R5: While bit 5 is low the count holds its value. Count and reload can both be written in this state.
- R6: A write to offset 0x08 sets the count on that edge. It wins over a tick that falls on the same edge.
- R7: When a tick takes the count from 1 to 0, `rst_req_o` is high for exactly the following cycle, but only if control bit 0 is set.
- R8: The same event sets `irq_o` if control bit 2 is set. `irq_o` then stays high until a control write. If a control write and the event fall on the same edge, `irq_o` is set.
- R9: A tick that finds the count at 0 loads the reload word and produces no event. This includes a 0 that software wrote directly.
- R10: Loading 0x80 into both count and reload and then writing control 0x2021 produces a reset request 0x80·33·16 = 67584 cycles after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the word (0x00, 0x04, 0x08) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed word, 0 when not reading |
| irq_o | output | 1 | Expiry interrupt, level |
| rst_req_o | output | 1 | Expiry reset request, one-cycle pulse |

## Verification
A scaler that is wrongly cleared, or that keeps stale state, shifts every event by a whole tick period, that is (P+1)·D cycles. It is therefore visible at the first expiry after enabling. A counter fault shows up in a count readback within one tick, or as a missed or extra event at the next expiry.

A wrong priority between a software load and a tick, or between the interrupt set and its clear, is seen only when both fall on one edge. The bench therefore times writes onto exact tick edges and event edges.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_RELOAD = 'h04;
  localparam int OFF_COUNT  = 'h08;

  localparam logic [15:0] CTRL_RESET   = 16'h8021;
  localparam logic [15:0] RELOAD_RESET = 16'h8000;

  typedef struct packed {
    logic [7:0] presc;
    logic [1:0] spare_hi;
    logic       run;
    logic [1:0] div_sel;
    logic       irq_en;
    logic       spare_lo;
    logic       rst_en;
  } ctrl_t;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              ctrl_wr_o,
  output logic              cnt_wr_o,
  output logic [15:0]       rdata_o
);

  logic hit_ctrl, hit_reload, hit_count;
  ctrl_t ctrl_q;
  logic [CNT_W-1:0] reload_q;

  assign hit_ctrl   = (addr_i == ADDR_W'(OFF_CTRL));
  assign hit_reload = (addr_i == ADDR_W'(OFF_RELOAD));
  assign hit_count  = (addr_i == ADDR_W'(OFF_COUNT));

  assign ctrl_wr_o = valid_i && write_i && hit_ctrl;
  assign cnt_wr_o  = valid_i && write_i && hit_count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= ctrl_t'(CTRL_RESET);
      reload_q <= CNT_W'(RELOAD_RESET);
    end else begin
      if (ctrl_wr_o) ctrl_q <= ctrl_t'(wdata_i);
      if (valid_i && write_i && hit_reload) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (valid_i && !write_i) begin
      if (hit_ctrl)        rdata_o = 16'(ctrl_q);
      else if (hit_reload) rdata_o = 16'(reload_q);
      else if (hit_count)  rdata_o = 16'(count_i);
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_o |=> (16'(ctrl_q) == $past(wdata_i))); // R2

endmodule

// File: rtl/wdt_scaler.sv
module wdt_scaler #(
  parameter int PRE_W    = 8,
  parameter int BASE_LOG = 4,
  parameter int SEL_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             tick_o
);

  localparam int NUM_DIV = 1 << SEL_W;
  localparam int DCNT_W  = BASE_LOG + NUM_DIV - 1;

  logic [PRE_W-1:0]   pre_cnt;
  logic [DCNT_W-1:0]  div_cnt;
  logic [NUM_DIV-1:0] div_hit;
  logic               pre_hit;

  // One terminal-count detector per selectable divide ratio.
  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div_tap
    assign div_hit[g] = &div_cnt[BASE_LOG+g-1:0];
  end

  assign pre_hit = (pre_cnt == presc_i);
  assign tick_o  = run_i && pre_hit && div_hit[div_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run_i) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_hit) begin
      pre_cnt <= '0;
      div_cnt <= div_hit[div_sel_i] ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  AST_FRESH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (pre_cnt == '0 && div_cnt == '0)); // R4
  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R3

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int          CNT_W      = 16,
  parameter logic [15:0] COUNT_INIT = 16'h8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             rst_en_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             rst_req_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] count_q;
  logic             irq_q, rst_q, expire;

  assign expire = tick_i && !cnt_wr_i && (count_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= CNT_W'(COUNT_INIT);
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      if (cnt_wr_i)    count_q <= wdata_i;
      else if (tick_i) count_q <= (count_q == '0) ? reload_i : count_q - 1'b1;
      rst_q <= expire && rst_en_i;
      if (expire && irq_en_i) irq_q <= 1'b1;
      else if (irq_clr_i)     irq_q <= 1'b0;
    end
  end

  assign count_o   = count_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R7
  AST_RST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(rst_en_i)); // R7
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_i)); // R8
  AST_SW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (count_o == $past(wdata_i))); // R6
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr_i && count_o == '0) |=> (count_o == $past(reload_i))); // R9
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(count_o)); // R5

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload, count;
  logic             ctrl_wr, cnt_wr, tick;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (bus_valid_i),
    .write_i   (bus_write_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .count_i   (count),
    .ctrl_o    (ctrl),
    .reload_o  (reload),
    .ctrl_wr_o (ctrl_wr),
    .cnt_wr_o  (cnt_wr),
    .rdata_o   (bus_rdata_o)
  );

  wdt_scaler #(.PRE_W(8), .BASE_LOG(4), .SEL_W(2)) u_scaler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl.run),
    .presc_i   (ctrl.presc),
    .div_sel_i (ctrl.div_sel),
    .tick_o    (tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .COUNT_INIT(RELOAD_RESET)) u_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .run_i     (ctrl.run),
    .cnt_wr_i  (cnt_wr),
    .wdata_i   (bus_wdata_i[CNT_W-1:0]),
    .reload_i  (reload),
    .rst_en_i  (ctrl.rst_en),
    .irq_en_i  (ctrl.irq_en),
    .irq_clr_i (ctrl_wr),
    .count_o   (count),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid, write;
  logic [3:0]  addr;
  logic [15:0] wdata, rdata;
  logic        irq, rst_req;

  always #5 clk = ~clk;

  wdog_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { string req; int kind; longint at; } ev_t;  // kind 0 reset request, 1 irq rise
  ev_t exp_q[$];

  task automatic check(string req, longint act, longint expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push(string req, int kind, longint at);
    ev_t e;
    e.req = req; e.kind = kind; e.at = at;
    exp_q.push_back(e);
  endtask

  task automatic pop_check(int kind);
    ev_t e;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R7/R8: unexpected event kind %0d at cycle %0d, expected none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        n_bad++;
        $display("FAIL %s: event kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // Monitor: compares observed events with the scoreboard queue.
  logic irq_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) pop_check(0);
      if (irq && !irq_prev) pop_check(1);
    end
    irq_prev = irq;
  end

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(logic [3:0] a, logic [15:0] d, output longint edge_at);
    valid = 1; write = 1; addr = a; wdata = d;
    @(negedge clk);
    valid = 0; write = 0;
    edge_at = cyc;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] v);
    valid = 1; write = 0; addr = a;
    #1 v = rdata;
    valid = 0;
  endtask

  task automatic wait_until(longint t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
    finish_run();
  end

  initial begin
    longint e, t;
    logic [15:0] v;
    rst_n = 0; valid = 0; write = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, v); check("R1 ctrl", v, 16'h8021);
    rd(4'h4, v); check("R1 reload", v, 16'h8000);
    rd(4'h8, v); check("R1 count", v, 16'h8000);
    check("R1 irq", irq, 0);
    check("R1 rst_req", rst_req, 0);

    // Stop, program while halted (R2, R5)
    wr(4'h0, 16'h0000, t);
    wr(4'h4, 16'd5, t);
    wr(4'h8, 16'd3, t);
    rd(4'h4, v); check("R2 reload readback", v, 5);
    rd(4'h8, v); check("R5 count written while stopped", v, 3);
    rd(4'hC, v); check("R2 unmapped read", v, 0);
    rd(4'h0, v); check("R2 ctrl readback", v, 0);
    wait_until(cyc + 50);
    rd(4'h8, v); check("R5 count held while stopped", v, 3);

    // P=1, div16 => 32 cycles/tick, irq+reset enabled
    wr(4'h0, 16'h0125, e);
    push("R7", 0, e + 96); push("R8", 1, e + 96);
    wait_until(e + 31); rd(4'h8, v); check("R4 no tick before full period", v, 3);
    wait_until(e + 32); rd(4'h8, v); check("R3 first decrement", v, 2);
    wait_until(e + 129); rd(4'h8, v); check("R9 reload after zero", v, 5);
    wait_until(e + 199); wr(4'h0, 16'h0125, t);
    check("R8 irq cleared by ctrl write", irq, 0);
    push("R7", 0, e + 288); push("R8", 1, e + 288);
    wait_until(e + 287); wr(4'h0, 16'h0125, t);
    check("R8 set wins over same-edge clear", irq, 1);
    wr(4'h0, 16'h0000, t);
    check("R8 irq cleared on stop", irq, 0);

    // div128, P=0, irq only: no reset request expected
    wr(4'h8, 16'd2, t);
    wr(4'h0, 16'h003C, e);
    push("R8", 1, e + 256);
    wait_until(e + 127); rd(4'h8, v); check("R3 div128 before tick", v, 2);
    wait_until(e + 128); rd(4'h8, v); check("R3 div128 tick", v, 1);
    wait_until(e + 260);
    check("R7 no reset request when disabled", rst_req, 0);
    wr(4'h0, 16'h0000, t);

    // Keep-alive write landing on a tick edge (R6)
    wr(4'h8, 16'd4, t);
    wr(4'h0, 16'h0021, e);
    wait_until(e + 47); wr(4'h8, 16'd4, t);
    rd(4'h8, v); check("R6 load wins over tick", v, 4);
    push("R6", 0, e + 112);
    wait_until(e + 115); wr(4'h0, 16'h0000, t);

    // Software-loaded zero reloads without an event (R9)
    wr(4'h4, 16'd2, t);
    wr(4'h8, 16'd0, t);
    wr(4'h0, 16'h0021, e);
    push("R9", 0, e + 48);
    wait_until(e + 16); rd(4'h8, v); check("R9 zero reloads silently", v, 2);
    wait_until(e + 50); wr(4'h0, 16'h0000, t);

    // Fast forced reset (R10)
    wr(4'h8, 16'h0080, t);
    wr(4'h4, 16'h0080, t);
    wr(4'h0, 16'h2021, e);
    push("R10", 0, e + 67584);
    wait_until(e + 67590); wr(4'h0, 16'h0000, t);

    repeat (4) @(negedge clk);
    while (exp_q.size() != 0) begin
      ev_t m;
      m = exp_q.pop_front();
      n_cmp++; n_bad++;
      $display("FAIL %s: event kind %0d missing, expected at cycle %0d", m.req, m.kind, m.at);
    end
    finish_run();
  end

endmodule